// File: doc/BRIEF.md
# Dataflow Thread Synchronization Scheduler

The scheduler keeps track of threads in a non-blocking dataflow processor while they wait for their inputs. A thread is registered with a frame pointer, an instruction pointer and the number of inputs it still needs. Every store into a thread's frame is reported to the scheduler, which counts that input off. A thread whose count reaches zero is enabled. Only at that point does it compete for one of a small set of hardware register contexts. Enabled threads wait in arrival order until a context is free.

Once a thread holds a context it spends a fixed hand-off period in pre-load. It is then offered to the execution side on a valid/ready dispatch port. After the execution side reports through the context-return port that the thread's body has finished, a post-store period of the same length follows. The context and the table entry are then released. Creation uses valid/ready: `create_ready` falls while all table entries are in use, and a create is taken only on a cycle where both are high. Dispatch also uses valid/ready: once `disp_valid` is raised, the offered thread and its payload stay unchanged until `disp_ready` is sampled high. Store notifications and context returns are plain one-cycle strobes that are never back-pressured.

Top module: `tsync_sched`

## Requirements
- R1: With defaults the table holds 8 threads. `full` is high and `create_ready` is low exactly when all entries are occupied. A create is taken only on a cycle where both `create_valid` and `create_ready` are high.
- R2: Each store strobe whose frame pointer matches a live thread that is waiting with a nonzero count lowers that count by one. The thread becomes enabled when its count reaches zero. A thread created with a count of zero is enabled at once.
- R3: A store strobe whose frame pointer matches no live thread, or matches a thread whose count is already zero, raises `store_err` for exactly the following cycle and changes no count.
- R4: A thread is bound to a register context only after it is enabled. It always receives the lowest-numbered free context, and at most one thread is bound per cycle.
- R5: Enabled threads receive contexts in the order in which they were enabled. When a store and a create enable threads on the same edge, the store's thread comes first. A thread with no free context waits until one is returned.
- R6: `disp_valid` rises HANDOFF cycles (4 by default) after the edge that binds the context. From that point `disp_fp`, `disp_ip` and `disp_ctx` hold steady until the cycle where `disp_ready` is high.
- R7: Threads are offered on the dispatch port in the same order in which they received contexts.
- R8: A context-return strobe naming the context of a dispatched thread starts that thread's post-store phase. The context and the table entry become free on the edge HANDOFF cycles after the strobe's edge. A strobe naming any other context does nothing.
- R9: After reset, `create_ready` is 1, `full` is 0, `disp_valid` is 0 and `store_err` is 0. No more threads than there are contexts ever hold a context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| create_valid | input | 1 | Thread-create request |
| create_ready | output | 1 | Table can accept a thread |
| create_fp | input | FP_W | Frame pointer of the new thread |
| create_ip | input | IP_W | Instruction pointer of the new thread |
| create_cnt | input | CNT_W | Number of inputs the thread needs |
| full | output | 1 | All table entries in use |
| store_valid | input | 1 | One input was stored into a frame |
| store_fp | input | FP_W | Frame pointer that received the store |
| store_err | output | 1 | Previous store strobe was not legal |
| ctxret_valid | input | 1 | Execution side finished a thread |
| ctxret_id | input | CTX_W | Context of the finished thread |
| disp_valid | output | 1 | A thread is ready for execution |
| disp_ready | input | 1 | Execution side takes the thread |
| disp_fp | output | FP_W | Frame pointer of the dispatched thread |
| disp_ip | output | IP_W | Instruction pointer of the dispatched thread |
| disp_ctx | output | CTX_W | Register context bound to the thread |

## Verification
A count that is wrong by one shows up in two ways. Either the dispatch port offers a thread one input too early or never, or `store_err` fires on a legal store one cycle after that store. A broken ready or dispatch queue shows up as frame pointers leaving the port in the wrong order. A lost or doubled context is visible from the context numbers handed out: the next thread to be bound receives a different one, and `create_ready` stays low longer than the table's occupancy allows. Because every output is compared with a behavioural model on every cycle, each of these faults is caught on the first cycle it reaches a pin.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  typedef enum logic [2:0] {
    PH_WAIT,
    PH_RDY,
    PH_PRE,
    PH_EXEC,
    PH_POST
  } phase_t;
endpackage

// File: rtl/tsync_fifo.sv
module tsync_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] data_a,
  input  logic         push_b,
  input  logic [W-1:0] data_b,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_a) mem[wp] <= data_a;
    if (push_b) mem[push_a ? step(wp) : wp] <= data_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      case ({push_a, push_b})
        2'b11:          wp <= step(step(wp));
        2'b10, 2'b01:   wp <= step(wp);
        default:        wp <= wp;
      endcase
      if (pop) rp <= step(rp);
      cnt <= cnt + CW'(push_a) + CW'(push_b) - CW'(pop);
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);

  // R5: the queue never takes more entries than it holds
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !pop) |-> !(push_a || push_b));
  // R5: nothing is granted from an empty queue
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tsync_ctx_pool.sv
module tsync_ctx_pool #(
  parameter int N_CTX = 4,
  localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [N_CTX-1:0] release_mask,
  output logic             avail,
  output logic [CTX_W-1:0] alloc_id,
  output logic [N_CTX-1:0] busy
);
  always_comb begin
    avail    = 1'b0;
    alloc_id = '0;
    for (int c = N_CTX - 1; c >= 0; c--) begin
      if (!busy[c]) begin
        avail    = 1'b1;
        alloc_id = CTX_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      busy <= (busy & ~release_mask) |
              (alloc ? (N_CTX'(1) << alloc_id) : '0);
    end
  end

  // R4: a context is bound only when one is free
  a_r4_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> avail);
  // R8: only contexts in use are handed back
  a_r8_release_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (release_mask & ~busy) == '0);
endmodule

// File: rtl/tsync_sched.sv
module tsync_sched
  import tsync_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int N_CTX     = 4,
  parameter int FP_W      = 8,
  parameter int IP_W      = 16,
  parameter int CNT_W     = 4,
  parameter int HANDOFF   = 4,
  localparam int CTX_W    = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             create_valid,
  output logic             create_ready,
  input  logic [FP_W-1:0]  create_fp,
  input  logic [IP_W-1:0]  create_ip,
  input  logic [CNT_W-1:0] create_cnt,
  output logic             full,
  input  logic             store_valid,
  input  logic [FP_W-1:0]  store_fp,
  output logic             store_err,
  input  logic             ctxret_valid,
  input  logic [CTX_W-1:0] ctxret_id,
  output logic             disp_valid,
  input  logic             disp_ready,
  output logic [FP_W-1:0]  disp_fp,
  output logic [IP_W-1:0]  disp_ip,
  output logic [CTX_W-1:0] disp_ctx
);
  localparam int SLOT_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int TMR_W  = $clog2(HANDOFF + 1);

  logic [N_ENTRIES-1:0] e_vld;
  phase_t               e_ph  [N_ENTRIES];
  logic [FP_W-1:0]      e_fp  [N_ENTRIES];
  logic [IP_W-1:0]      e_ip  [N_ENTRIES];
  logic [CNT_W-1:0]     e_cnt [N_ENTRIES];
  logic [CTX_W-1:0]     e_ctx [N_ENTRIES];
  logic [TMR_W-1:0]     e_tmr [N_ENTRIES];

  logic [SLOT_W-1:0] alloc_idx, st_idx, rq_head, dq_head;
  logic              st_hit, st_ok, st_bad, st_zero;
  logic              cr_fire, cr_zero;
  logic              rq_empty, dq_empty, grant, fire;
  logic              ctx_avail;
  logic [CTX_W-1:0]  ctx_id;
  logic [N_CTX-1:0]  ctx_busy, rel_mask;
  logic [N_ENTRIES-1:0] hold_mask;

  // free slot and create acceptance
  always_comb begin
    alloc_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (!e_vld[i]) alloc_idx = SLOT_W'(i);
  end
  assign full         = &e_vld;
  assign create_ready = ~full;
  assign cr_fire      = create_valid & ~full;
  assign cr_zero      = cr_fire & (create_cnt == '0);

  // store matching
  always_comb begin
    st_hit = 1'b0;
    st_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (e_vld[i] && e_fp[i] == store_fp) begin
        st_hit = 1'b1;
        st_idx = SLOT_W'(i);
      end
    end
  end
  assign st_ok   = store_valid & st_hit & (e_ph[st_idx] == PH_WAIT);
  assign st_bad  = store_valid & ~st_ok;
  assign st_zero = st_ok & (e_cnt[st_idx] == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) store_err <= 1'b0;
    else        store_err <= st_bad;
  end

  // enabled threads waiting for a context
  tsync_fifo #(.W(SLOT_W), .DEPTH(N_ENTRIES)) u_readyq (
    .clk(clk), .rst_n(rst_n),
    .push_a(st_zero), .data_a(st_idx),
    .push_b(cr_zero), .data_b(alloc_idx),
    .pop(grant), .head(rq_head), .empty(rq_empty)
  );

  assign grant = ~rq_empty & ctx_avail;

  // threads holding a context, in grant order
  tsync_fifo #(.W(SLOT_W), .DEPTH(N_CTX)) u_dispq (
    .clk(clk), .rst_n(rst_n),
    .push_a(grant), .data_a(rq_head),
    .push_b(1'b0), .data_b('0),
    .pop(fire), .head(dq_head), .empty(dq_empty)
  );

  assign disp_valid = ~dq_empty & (e_ph[dq_head] == PH_PRE) & (e_tmr[dq_head] == '0);
  assign fire       = disp_valid & disp_ready;
  assign disp_fp    = e_fp[dq_head];
  assign disp_ip    = e_ip[dq_head];
  assign disp_ctx   = e_ctx[dq_head];

  always_comb begin
    rel_mask  = '0;
    hold_mask = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (e_vld[i] && e_ph[i] == PH_POST && e_tmr[i] == '0)
        rel_mask[e_ctx[i]] = 1'b1;
      hold_mask[i] = e_vld[i] &&
        (e_ph[i] == PH_PRE || e_ph[i] == PH_EXEC || e_ph[i] == PH_POST);
    end
  end

  tsync_ctx_pool #(.N_CTX(N_CTX)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc(grant), .release_mask(rel_mask),
    .avail(ctx_avail), .alloc_id(ctx_id), .busy(ctx_busy)
  );

  // per-entry lifecycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        e_ph[i]  <= PH_WAIT;
        e_fp[i]  <= '0;
        e_ip[i]  <= '0;
        e_cnt[i] <= '0;
        e_ctx[i] <= '0;
        e_tmr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (e_vld[i]) begin
          case (e_ph[i])
            PH_WAIT: if (st_ok && st_idx == SLOT_W'(i)) begin
              e_cnt[i] <= e_cnt[i] - 1'b1;
              if (st_zero) e_ph[i] <= PH_RDY;
            end
            PH_RDY: if (grant && rq_head == SLOT_W'(i)) begin
              e_ph[i]  <= PH_PRE;
              e_ctx[i] <= ctx_id;
              e_tmr[i] <= TMR_W'(HANDOFF);
            end
            PH_PRE: begin
              if (e_tmr[i] != '0)
                e_tmr[i] <= e_tmr[i] - 1'b1;
              else if (fire && dq_head == SLOT_W'(i))
                e_ph[i] <= PH_EXEC;
            end
            PH_EXEC: if (ctxret_valid && ctxret_id == e_ctx[i]) begin
              e_ph[i]  <= PH_POST;
              e_tmr[i] <= TMR_W'(HANDOFF - 1);
            end
            PH_POST: begin
              if (e_tmr[i] == '0) e_vld[i] <= 1'b0;
              else                e_tmr[i] <= e_tmr[i] - 1'b1;
            end
            default: e_ph[i] <= PH_WAIT;
          endcase
        end else if (cr_fire && alloc_idx == SLOT_W'(i)) begin
          e_vld[i] <= 1'b1;
          e_fp[i]  <= create_fp;
          e_ip[i]  <= create_ip;
          e_cnt[i] <= create_cnt;
          e_ph[i]  <= cr_zero ? PH_RDY : PH_WAIT;
        end
      end
    end
  end

  // R6: an offered thread is held until taken
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=>
      (disp_valid && $stable(disp_fp) && $stable(disp_ip) && $stable(disp_ctx)));
  // R4: the dispatched context is marked in use by the pool
  a_r4_disp_ctx_busy: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ctx_busy[disp_ctx]);
  // R9: threads holding a context match contexts in use
  a_r9_ctx_accounting: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hold_mask) == $countones(ctx_busy));
endmodule

// File: tb/tsync_sched_test.sv
module tsync_sched_test;
  localparam int NE = 8;
  localparam int NC = 4;
  localparam int H  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       create_valid = 1'b0;
  logic       create_ready;
  logic [7:0] create_fp = '0;
  logic [15:0] create_ip = '0;
  logic [3:0] create_cnt = '0;
  logic       full;
  logic       store_valid = 1'b0;
  logic [7:0] store_fp = '0;
  logic       store_err;
  logic       ctxret_valid = 1'b0;
  logic [1:0] ctxret_id = '0;
  logic       disp_valid;
  logic       disp_ready = 1'b0;
  logic [7:0] disp_fp;
  logic [15:0] disp_ip;
  logic [1:0] disp_ctx;

  always #5 clk = ~clk;

  tsync_sched uut (
    .clk(clk), .rst_n(rst_n),
    .create_valid(create_valid), .create_ready(create_ready),
    .create_fp(create_fp), .create_ip(create_ip), .create_cnt(create_cnt),
    .full(full),
    .store_valid(store_valid), .store_fp(store_fp), .store_err(store_err),
    .ctxret_valid(ctxret_valid), .ctxret_id(ctxret_id),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_fp(disp_fp), .disp_ip(disp_ip), .disp_ctx(disp_ctx)
  );

  // behavioural model: 0 free, 1 waiting, 2 enabled, 3 pre-load, 4 execute, 5 post-store
  int st [256];
  int mcnt [256];
  int mip [256];
  int mctx [256];
  int mtmr [256];
  int rq [$];
  int dq [$];
  bit cbusy [NC];
  int live;
  bit err_exp;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  function automatic bit dv_exp();
    return dq.size() > 0 && st[dq[0]] == 3 && mtmr[dq[0]] == 0;
  endfunction

  always @(posedge clk) begin
    bit fire;
    int gctx;
    int live0;
    int f;
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) st[k] = 0;
      rq.delete();
      dq.delete();
      for (int c = 0; c < NC; c++) cbusy[c] = 1'b0;
      live = 0;
      err_exp = 1'b0;
    end else begin
      fire = dv_exp() && disp_ready;
      live0 = live;
      gctx = -1;
      for (int c = NC - 1; c >= 0; c--) if (!cbusy[c]) gctx = c;
      for (int k = 0; k < 256; k++) begin
        if (st[k] == 3 && mtmr[k] > 0) mtmr[k]--;
        else if (st[k] == 5) begin
          if (mtmr[k] == 0) begin st[k] = 0; cbusy[mctx[k]] = 1'b0; live--; end
          else mtmr[k]--;
        end
      end
      if (ctxret_valid)
        for (int k = 0; k < 256; k++)
          if (st[k] == 4 && mctx[k] == int'(ctxret_id)) begin st[k] = 5; mtmr[k] = H - 1; end
      if (fire) begin f = dq.pop_front(); st[f] = 4; end
      if (rq.size() > 0 && gctx >= 0) begin
        f = rq.pop_front();
        st[f] = 3; mtmr[f] = H; mctx[f] = gctx; cbusy[gctx] = 1'b1;
        dq.push_back(f);
      end
      err_exp = 1'b0;
      if (store_valid) begin
        if (st[store_fp] == 1) begin
          mcnt[store_fp]--;
          if (mcnt[store_fp] == 0) begin st[store_fp] = 2; rq.push_back(int'(store_fp)); end
        end else err_exp = 1'b1;
      end
      if (create_valid && live0 < NE) begin
        live++;
        mip[create_fp] = int'(create_ip);
        mcnt[create_fp] = int'(create_cnt);
        if (create_cnt == 0) begin st[create_fp] = 2; rq.push_back(int'(create_fp)); end
        else st[create_fp] = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk("R1 create_ready", int'(create_ready), int'(live < NE));
      chk("R1 full", int'(full), int'(live >= NE));
      chk("R3 store_err", int'(store_err), int'(err_exp));
      chk("R2 R6 disp_valid", int'(disp_valid), int'(dv_exp()));
      if (dv_exp()) begin
        chk("R5 R7 disp_fp", int'(disp_fp), dq[0]);
        chk("R6 disp_ip", int'(disp_ip), mip[dq[0]]);
        chk("R4 R8 disp_ctx", int'(disp_ctx), mctx[dq[0]]);
      end
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    create_valid = 1'b0;
    store_valid = 1'b0;
    ctxret_valid = 1'b0;
  endtask

  initial begin
    tick();
    tick();
    // R9 reset state
    chk("R9 reset create_ready", int'(create_ready), 1);
    chk("R9 reset disp_valid", int'(disp_valid), 0);
    chk("R9 reset store_err", int'(store_err), 0);
    rst_n = 1'b1;
    tick();
    // R1 fill the table, ninth request refused
    for (int k = 0; k < 9; k++) begin
      idle();
      create_valid = 1'b1; create_fp = 8'(20 + k); create_ip = 16'(100 + k); create_cnt = 4'd1;
      tick();
    end
    idle();
    tick();
    // R2 R5 enable all; only four contexts
    for (int k = 0; k < 8; k++) begin
      idle();
      store_valid = 1'b1; store_fp = 8'(20 + k);
      tick();
    end
    idle();
    for (int k = 0; k < 12; k++) tick();
    disp_ready = 1'b1;
    for (int k = 0; k < 10; k++) tick();
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < NC; c++) begin
        idle(); ctxret_valid = 1'b1; ctxret_id = 2'(c); tick();
      end
      idle();
      for (int k = 0; k < 14; k++) tick();
    end
    // R3 store to a freed frame, then to an already enabled one
    idle(); store_valid = 1'b1; store_fp = 8'd20; tick();
    idle(); create_valid = 1'b1; create_fp = 8'd50; create_ip = 16'd7; create_cnt = 4'd1; tick();
    idle(); store_valid = 1'b1; store_fp = 8'd50; tick();
    idle(); store_valid = 1'b1; store_fp = 8'd50; tick();
    // R5 same-edge enable by store and by zero-count create
    idle(); create_valid = 1'b1; create_fp = 8'd51; create_ip = 16'd8; create_cnt = 4'd1; tick();
    idle(); store_valid = 1'b1; store_fp = 8'd51;
    create_valid = 1'b1; create_fp = 8'd52; create_ip = 16'd9; create_cnt = 4'd0; tick();
    idle();
    for (int k = 0; k < 12; k++) tick();
    // random traffic
    for (int k = 0; k < 5000; k++) begin
      int fp;
      idle();
      fp = int'($urandom_range(0, 63));
      if ($urandom_range(0, 9) < 3 && st[fp] == 0) begin
        create_valid = 1'b1; create_fp = 8'(fp);
        create_ip = 16'($urandom_range(0, 65535)); create_cnt = 4'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 9) < 5) begin
        store_valid = 1'b1; store_fp = 8'($urandom_range(0, 63));
      end
      if ($urandom_range(0, 9) < 2) begin
        ctxret_valid = 1'b1; ctxret_id = 2'($urandom_range(0, NC - 1));
      end
      disp_ready = ($urandom_range(0, 9) < 6);
      tick();
    end
    idle();
    disp_ready = 1'b1;
    for (int k = 0; k < 100; k++) begin
      ctxret_valid = 1'b1; ctxret_id = 2'(k % NC);
      tick();
    end
    idle();
    tick();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule